// File: doc/BRIEF.md
# Time-of-Day Alarm Matcher and Interrupt Router

This block decides when a time-of-day alarm fires and drives two active-low interrupt pins. It holds three alarm bytes: minutes, hours and day of week. Bit 7 of each byte is a mask bit. Once per second the clock core raises a check strobe and presents the time the counters are about to take. The block compares that time with the alarm bytes, and only a fixed set of mask patterns is honoured. A hit sets the time-of-day flag. Any read or write of an alarm byte clears that flag.

The flag and a request from a separate watchdog are each shaped into an interrupt. In level mode an interrupt stays asserted until its source clears. In pulse mode it is a fixed-length pulse, and the flag reads 1 only while the pulse lasts. A control byte sets the following: which interrupt drives which pin, pulse or level mode, and a mask for each source. Both pins are modelled as open-drain enables, so 0 means the pin is pulled low.

Top module: `tod_alarm_irq`

## Requirements
- R1: The alarm bytes are selected by `acc_sel`: 0 is minutes, 1 is hours, 2 is day, and 3 reads 0 and stores nothing. A write to minutes or hours stores all 8 bits. A write to day stores only bits 7 and 2..0, so bits 6..3 of the day byte always read 0.
- R2: When the masks {minutes bit 7, hours bit 7, day bit 7} are 1,1,1, a check strobe with `nxt_sec` equal to 8'h00 raises an alarm, whatever the other time values are.
- R3: When the masks are 0,1,1, an alarm needs `nxt_sec`=8'h00 and bits 6..0 of `nxt_min` equal to bits 6..0 of the minutes byte.
- R4: When the masks are 0,0,1, an alarm also needs bits 6..0 of `nxt_hour` to equal bits 6..0 of the hours byte.
- R5: When the masks are 0,0,0, an alarm also needs bits 2..0 of `nxt_day` to equal bits 2..0 of the day byte.
- R6: Every other mask pattern (1,0,1; 1,1,0; 1,0,0; 0,1,0) never raises an alarm.
- R7: An alarm is taken only in a cycle where `chk_stb` is 1. `tdf` rises on the clock edge that samples that strobe.
- R8: Any alarm-byte access (`acc_stb`=1, read or write) clears `tdf` on that edge. A clear wins over an alarm hit in the same cycle.
- R9: `cmd[2]`=1 blocks the time-of-day interrupt from its pin and leaves `tdf` unchanged. `cmd[3]`=1 blocks the watchdog interrupt.
- R10: With `cmd[6]`=1, `inta_n` carries the time-of-day interrupt and `intb_n` carries the watchdog interrupt. With `cmd[6]`=0 the two are swapped.
- R11: With `cmd[4]`=0 (level mode), the time-of-day interrupt holds until an access clears it. The watchdog interrupt asserts on the edge after `wd_req` rises and releases on the edge after `wd_req` falls.
- R12: With `cmd[4]`=1 (pulse mode), each event asserts its interrupt for exactly PULSE_CYC cycles and then releases it, even if `wd_req` stays high. `tdf` is 1 only during the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_stb | input | 1 | Once-per-second alarm check strobe |
| nxt_sec | input | 8 | BCD seconds the clock is about to take |
| nxt_min | input | 8 | BCD minutes the clock is about to take |
| nxt_hour | input | 8 | Hours the clock is about to take (12/24 format bits included) |
| nxt_day | input | 8 | Day of week the clock is about to take |
| acc_stb | input | 1 | Alarm-byte access strobe (read or write) |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 2 | Alarm byte select |
| acc_wdata | input | 8 | Write data |
| alm_rdata | output | 8 | Read data of the selected alarm byte |
| wd_req | input | 1 | Watchdog expiry request, level |
| cmd | input | 8 | Control byte: bit 6 swap, bit 4 pulse, bit 3 watchdog mask, bit 2 time-of-day mask |
| tdf | output | 1 | Time-of-day alarm flag |
| inta_n | output | 1 | Interrupt pin A, active low |
| intb_n | output | 1 | Interrupt pin B, active low |

## Verification
The assertions check the following on every cycle:
- an access always leaves the flag clear on the next cycle;
- the flag rises only just after a check strobe;
- an alarm hit never occurs outside a second rollover;
- the padding bits of the day byte read zero;
- the pins stay released while both masks are set;
- a level-mode interrupt never drops without a clear.

Only the bench scenarios can show which time values and mask patterns actually match, that the pins swap correctly, and that a pulse lasts exactly the set number of cycles.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int BYTE_W   = 8;
  localparam int SEL_W    = 2;
  localparam int CMD_SWAP = 6;
  localparam int CMD_PULS = 4;
  localparam int CMD_WMSK = 3;
  localparam int CMD_TMSK = 2;
  localparam logic [BYTE_W-1:0] DAY_KEEP = 8'h87;

  typedef enum logic [SEL_W-1:0] {
    SEL_MIN  = 2'd0,
    SEL_HOUR = 2'd1,
    SEL_DAY  = 2'd2,
    SEL_NONE = 2'd3
  } alm_sel_e;

  // The mask bits {min,hour,day} choose how much of the time must match.
  function automatic logic alarm_hit(
    input logic [BYTE_W-1:0] a_min, a_hour, a_day,
    input logic [BYTE_W-1:0] t_sec, t_min, t_hour, t_day);
    logic eq_m, eq_h, eq_d, res;
    eq_m = (a_min[6:0]  == t_min[6:0]);
    eq_h = (a_hour[6:0] == t_hour[6:0]);
    eq_d = (a_day[2:0]  == t_day[2:0]);
    case ({a_min[7], a_hour[7], a_day[7]})
      3'b111:  res = 1'b1;
      3'b011:  res = eq_m;
      3'b001:  res = eq_m & eq_h;
      3'b000:  res = eq_m & eq_h & eq_d;
      default: res = 1'b0;
    endcase
    return res & (t_sec == '0);
  endfunction
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import alm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic [BYTE_W-1:0] min_q,
  output logic [BYTE_W-1:0] hour_q,
  output logic [BYTE_W-1:0] day_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      min_q  <= '0;
      hour_q <= '0;
      day_q  <= '0;
    end else if (wr_en) begin
      case (alm_sel_e'(sel))
        SEL_MIN:  min_q  <= wdata;
        SEL_HOUR: hour_q <= wdata;
        SEL_DAY:  day_q  <= wdata & DAY_KEEP;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (alm_sel_e'(sel))
      SEL_MIN:  rdata = min_q;
      SEL_HOUR: rdata = hour_q;
      SEL_DAY:  rdata = day_q;
      default:  rdata = '0;
    endcase
  end

  // R1: padding bits of the day byte read as zero
  p_day_pad_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_DAY) |-> (rdata[6:3] == 4'b0000));
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import alm_pkg::*;
(
  input  logic              chk_stb,
  input  logic [BYTE_W-1:0] a_min,
  input  logic [BYTE_W-1:0] a_hour,
  input  logic [BYTE_W-1:0] a_day,
  input  logic [BYTE_W-1:0] t_sec,
  input  logic [BYTE_W-1:0] t_min,
  input  logic [BYTE_W-1:0] t_hour,
  input  logic [BYTE_W-1:0] t_day,
  output logic              hit
);
  assign hit = chk_stb & alarm_hit(a_min, a_hour, a_day, t_sec, t_min, t_hour, t_day);
endmodule

// File: rtl/irq_chan.sv
module irq_chan #(
  parameter int PULSE_CYC = 16,
  localparam int CW = $clog2(PULSE_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic pulse_i,
  output logic flag_o
);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
      left_q <= '0;
    end else if (clr_i) begin
      flag_o <= 1'b0;
      left_q <= '0;
    end else if (set_i) begin
      flag_o <= 1'b1;
      left_q <= CW'(PULSE_CYC - 1);
    end else if (flag_o && pulse_i) begin
      if (left_q == '0) flag_o <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end

  // R11: in level mode a raised flag only falls through a clear
  p_level_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !pulse_i && !clr_i) |=> flag_o);
endmodule

// File: rtl/tod_alarm_irq.sv
module tod_alarm_irq
  import alm_pkg::*;
#(
  parameter int PULSE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_stb,
  input  logic [BYTE_W-1:0] nxt_sec,
  input  logic [BYTE_W-1:0] nxt_min,
  input  logic [BYTE_W-1:0] nxt_hour,
  input  logic [BYTE_W-1:0] nxt_day,
  input  logic              acc_stb,
  input  logic              acc_we,
  input  logic [SEL_W-1:0]  acc_sel,
  input  logic [BYTE_W-1:0] acc_wdata,
  output logic [BYTE_W-1:0] alm_rdata,
  input  logic              wd_req,
  input  logic [BYTE_W-1:0] cmd,
  output logic              tdf,
  output logic              inta_n,
  output logic              intb_n
);
  localparam int NCH = 2;
  localparam int CH_TOD = 0;
  localparam int CH_WD  = 1;

  logic [BYTE_W-1:0] a_min, a_hour, a_day;
  logic hit_evt;
  logic wd_q;
  logic [NCH-1:0] set_v, clr_v, flag_v;
  logic tod_act, wd_act;
  logic unused_cmd;

  assign unused_cmd = ^{cmd[7], cmd[5], cmd[1:0]};

  alarm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(acc_stb & acc_we), .sel(acc_sel),
    .wdata(acc_wdata), .rdata(alm_rdata),
    .min_q(a_min), .hour_q(a_hour), .day_q(a_day));

  alarm_match u_match (
    .chk_stb(chk_stb), .a_min(a_min), .a_hour(a_hour), .a_day(a_day),
    .t_sec(nxt_sec), .t_min(nxt_min), .t_hour(nxt_hour), .t_day(nxt_day),
    .hit(hit_evt));

  always_ff @(posedge clk) begin
    if (!rst_n) wd_q <= 1'b0;
    else        wd_q <= wd_req;
  end

  assign set_v[CH_TOD] = hit_evt;
  assign clr_v[CH_TOD] = acc_stb;
  assign set_v[CH_WD]  = wd_req & ~wd_q;
  assign clr_v[CH_WD]  = ~wd_req;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    irq_chan #(.PULSE_CYC(PULSE_CYC)) u_chan (
      .clk(clk), .rst_n(rst_n), .set_i(set_v[g]), .clr_i(clr_v[g]),
      .pulse_i(cmd[CMD_PULS]), .flag_o(flag_v[g]));
  end

  assign tdf     = flag_v[CH_TOD];
  assign tod_act = flag_v[CH_TOD] & ~cmd[CMD_TMSK];
  assign wd_act  = flag_v[CH_WD]  & ~cmd[CMD_WMSK];
  assign inta_n  = ~(cmd[CMD_SWAP] ? tod_act : wd_act);
  assign intb_n  = ~(cmd[CMD_SWAP] ? wd_act  : tod_act);

  // R8: an access leaves the flag clear
  p_acc_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stb |=> !tdf);
  // R7: the flag rises only right after a check strobe
  p_rise_after_chk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tdf) |-> $past(chk_stb));
  // R2: a hit only happens on a second rollover to 00
  p_hit_on_rollover_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |-> (nxt_sec == 8'h00));
  // R9: both masks set keep both pins released
  p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd[CMD_TMSK] && cmd[CMD_WMSK]) |-> (inta_n && intb_n));
endmodule

// File: tb/tb_tod_alarm_irq.sv
module tb_tod_alarm_irq;
  localparam int P = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chk_stb = 1'b0;
  logic [7:0] nxt_sec = 8'h10, nxt_min = '0, nxt_hour = '0, nxt_day = '0;
  logic acc_stb = 1'b0, acc_we = 1'b0;
  logic [1:0] acc_sel = '0;
  logic [7:0] acc_wdata = '0;
  logic [7:0] alm_rdata;
  logic wd_req = 1'b0;
  logic [7:0] cmd = 8'h40;
  logic tdf, inta_n, intb_n;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  tod_alarm_irq #(.PULSE_CYC(P)) dut (
    .clk(clk), .rst_n(rst_n), .chk_stb(chk_stb), .nxt_sec(nxt_sec),
    .nxt_min(nxt_min), .nxt_hour(nxt_hour), .nxt_day(nxt_day),
    .acc_stb(acc_stb), .acc_we(acc_we), .acc_sel(acc_sel),
    .acc_wdata(acc_wdata), .alm_rdata(alm_rdata), .wd_req(wd_req),
    .cmd(cmd), .tdf(tdf), .inta_n(inta_n), .intb_n(intb_n));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); acc_stb = 1; acc_we = 1; acc_sel = sel; acc_wdata = d;
    @(negedge clk); acc_stb = 0; acc_we = 0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk); acc_stb = 1; acc_we = 0; acc_sel = sel;
    #1 d = alm_rdata;
    @(negedge clk); acc_stb = 0;
  endtask

  task automatic masks(input logic [7:0] m, h, d);
    wr(0, m); wr(1, h); wr(2, d);
  endtask

  task automatic strobe(input logic [7:0] s, m, h, d, input bit with_rd);
    @(negedge clk);
    nxt_sec = s; nxt_min = m; nxt_hour = h; nxt_day = d; chk_stb = 1;
    if (with_rd) begin acc_stb = 1; acc_we = 0; acc_sel = 0; end
    @(negedge clk); chk_stb = 0; acc_stb = 0; nxt_sec = 8'h10;
  endtask

  task automatic clr_flag();
    logic [7:0] d;
    rd(0, d);
  endtask

  task automatic t_reset();
    chk("R8 reset tdf", {7'b0, tdf}, 8'h00);
    chk("R10 reset inta_n", {7'b0, inta_n}, 8'h01);
    chk("R10 reset intb_n", {7'b0, intb_n}, 8'h01);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(0, 8'h85); rd(0, d); chk("R1 minutes byte", d, 8'h85);
    wr(1, 8'h52); rd(1, d); chk("R1 hours byte", d, 8'h52);
    wr(2, 8'hFF); rd(2, d); chk("R1 day padding", d, 8'h87);
    wr(3, 8'hAA); rd(3, d); chk("R1 unused select", d, 8'h00);
    rd(0, d); chk("R1 minutes kept", d, 8'h85);
  endtask

  task automatic t_every_min();
    masks(8'h80, 8'h80, 8'h80);
    strobe(8'h00, 8'h17, 8'h05, 8'h02, 0);
    chk("R2 per-minute alarm", {7'b0, tdf}, 8'h01);
    chk("R2 inta_n low", {7'b0, inta_n}, 8'h00);
    clr_flag();
    strobe(8'h30, 8'h17, 8'h05, 8'h02, 0);
    chk("R2 no alarm mid-minute", {7'b0, tdf}, 8'h00);
  endtask

  task automatic t_min_match();
    masks(8'h25, 8'h80, 8'h80);
    strobe(8'h00, 8'h25, 8'h09, 8'h01, 0);
    chk("R3 minute match", {7'b0, tdf}, 8'h01);
    clr_flag();
    strobe(8'h00, 8'h26, 8'h09, 8'h01, 0);
    chk("R3 minute mismatch", {7'b0, tdf}, 8'h00);
  endtask

  task automatic t_hm_match();
    masks(8'h25, 8'h13, 8'h80);
    strobe(8'h00, 8'h25, 8'h13, 8'h06, 0);
    chk("R4 hour+minute match", {7'b0, tdf}, 8'h01);
    clr_flag();
    strobe(8'h00, 8'h25, 8'h14, 8'h06, 0);
    chk("R4 hour mismatch", {7'b0, tdf}, 8'h00);
  endtask

  task automatic t_full_match();
    masks(8'h25, 8'h13, 8'h03);
    strobe(8'h00, 8'h25, 8'h13, 8'h03, 0);
    chk("R5 full match", {7'b0, tdf}, 8'h01);
    clr_flag();
    strobe(8'h00, 8'h25, 8'h13, 8'h04, 0);
    chk("R5 day mismatch", {7'b0, tdf}, 8'h00);
  endtask

  task automatic t_bad_masks();
    masks(8'h80, 8'h13, 8'h83);
    strobe(8'h00, 8'h00, 8'h13, 8'h03, 0);
    chk("R6 pattern 101", {7'b0, tdf}, 8'h00);
    masks(8'h80, 8'h93, 8'h03);
    strobe(8'h00, 8'h00, 8'h13, 8'h03, 0);
    chk("R6 pattern 110", {7'b0, tdf}, 8'h00);
    masks(8'h25, 8'h93, 8'h03);
    strobe(8'h00, 8'h25, 8'h13, 8'h03, 0);
    chk("R6 pattern 010", {7'b0, tdf}, 8'h00);
  endtask

  task automatic t_no_strobe();
    masks(8'h25, 8'h13, 8'h03);
    @(negedge clk);
    nxt_sec = 8'h00; nxt_min = 8'h25; nxt_hour = 8'h13; nxt_day = 8'h03;
    repeat (3) @(negedge clk);
    chk("R7 no strobe no alarm", {7'b0, tdf}, 8'h00);
    nxt_sec = 8'h10;
    strobe(8'h01, 8'h25, 8'h13, 8'h03, 0);
    chk("R7 strobe at wrong second", {7'b0, tdf}, 8'h00);
  endtask

  task automatic t_clear();
    masks(8'h80, 8'h80, 8'h80);
    strobe(8'h00, 8'h00, 8'h00, 8'h00, 0);
    chk("R8 flag set", {7'b0, tdf}, 8'h01);
    clr_flag();
    chk("R8 read clears", {7'b0, tdf}, 8'h00);
    strobe(8'h00, 8'h00, 8'h00, 8'h00, 0);
    wr(2, 8'h80);
    chk("R8 write clears", {7'b0, tdf}, 8'h00);
    strobe(8'h00, 8'h00, 8'h00, 8'h00, 1);
    chk("R8 clear beats hit", {7'b0, tdf}, 8'h00);
  endtask

  task automatic t_tod_mask();
    cmd = 8'h44;
    masks(8'h80, 8'h80, 8'h80);
    strobe(8'h00, 8'h00, 8'h00, 8'h00, 0);
    chk("R9 tdf still set", {7'b0, tdf}, 8'h01);
    chk("R9 inta_n blocked", {7'b0, inta_n}, 8'h01);
    cmd = 8'h40; #1;
    chk("R9 inta_n unblocked", {7'b0, inta_n}, 8'h00);
    clr_flag();
  endtask

  task automatic t_swap();
    cmd = 8'h00;
    masks(8'h80, 8'h80, 8'h80);
    strobe(8'h00, 8'h00, 8'h00, 8'h00, 0);
    chk("R10 swapped tod on intb_n", {7'b0, intb_n}, 8'h00);
    chk("R10 swapped inta_n idle", {7'b0, inta_n}, 8'h01);
    wd_req = 1; @(negedge clk);
    chk("R10 swapped wd on inta_n", {7'b0, inta_n}, 8'h00);
    clr_flag();
    cmd = 8'h40; #1;
    chk("R10 wd on intb_n", {7'b0, intb_n}, 8'h00);
    chk("R10 inta_n idle", {7'b0, inta_n}, 8'h01);
    wd_req = 0; @(negedge clk);
  endtask

  task automatic t_level();
    cmd = 8'h40;
    masks(8'h80, 8'h80, 8'h80);
    strobe(8'h00, 8'h00, 8'h00, 8'h00, 0);
    repeat (20) @(negedge clk);
    chk("R11 level tdf held", {7'b0, tdf}, 8'h01);
    chk("R11 level inta_n held", {7'b0, inta_n}, 8'h00);
    clr_flag();
    wd_req = 1; @(negedge clk);
    repeat (10) @(negedge clk);
    chk("R11 wd level held", {7'b0, intb_n}, 8'h00);
    cmd = 8'h48; #1;
    chk("R9 wd mask", {7'b0, intb_n}, 8'h01);
    cmd = 8'h40;
    wd_req = 0; @(negedge clk);
    chk("R11 wd release", {7'b0, intb_n}, 8'h01);
  endtask

  task automatic t_pulse();
    int n;
    cmd = 8'h50;
    masks(8'h80, 8'h80, 8'h80);
    strobe(8'h00, 8'h00, 8'h00, 8'h00, 0);
    n = 0;
    while (tdf && n < 100) begin
      if (inta_n !== 1'b0) n = 200;
      n++; @(negedge clk);
    end
    chk("R12 tod pulse length", 8'(n), 8'(P));
    chk("R12 inta_n released", {7'b0, inta_n}, 8'h01);
    @(negedge clk); wd_req = 1; @(negedge clk);
    n = 0;
    while (!intb_n && n < 100) begin n++; @(negedge clk); end
    chk("R12 wd pulse length", 8'(n), 8'(P));
    repeat (3) @(negedge clk);
    chk("R12 wd released while req high", {7'b0, intb_n}, 8'h01);
    wd_req = 0; cmd = 8'h40; @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_every_min();
    t_min_match();
    t_hm_match();
    t_full_match();
    t_bad_masks();
    t_no_strobe();
    t_clear();
    t_tod_mask();
    t_swap();
    t_level();
    t_pulse();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule